// File: doc/BRIEF.md
# CIC Decimation Filter with Counter-Driven Comb Enable

This block reduces the sample rate of a signed data stream by an integer ratio R, which is chosen at run time. It uses a cascade of N accumulators followed by N differencing stages. The accumulators take every accepted input sample. A reloading down counter picks one sample in every R, and only on that sample do the differencing stages move and a result come out. Because the rate is reduced before the differencing, each differencing stage needs a memory of only one decimated sample. It does not need R input samples.

The overall response is N boxcar filters in series, each with R unit taps, read at every R-th accepted input. The internal width is large enough for the full gain R^N at the largest ratio, so the result carries full precision and is never rounded. Intermediate sums may wrap in two's complement. The final difference is still exact. A new ratio takes effect only at a decimation point, so each output period uses a single ratio from start to end.

Top module: `cic_decimator`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: Accepted samples (`in_valid` high) are numbered 0, 1, 2, ... from reset. Sample 0 is a decimation point, and each later decimation point comes a number of accepted samples after the previous one equal to the `ratio` present at that previous point. `out_valid` is high for exactly one cycle, in the cycle after a decimation point is accepted, and is low otherwise.
- R3: A result for accepted sample n is equal to sum over k of h[k]·x[n−k]. Here h is the N-fold self-convolution of a length-R all-ones sequence, and inputs before reset count as zero.
- R4: A constant input v settles to an output of v·R^N.
- R5: A cycle with `in_valid` low changes no filter state. It gives `out_valid` 0 and `out_data` holds its previous value. `out_data` also holds in every cycle without `out_valid`.
- R6: A change of `ratio` in the middle of a period does not change the length of that period. The new ratio first sets the length of the period that begins at the next decimation point.
- R7: `out_data` is ACC_W = IN_W + N·ceil(log2(R_MAX)) bits wide and is exact in two's complement, with no saturation. At N=3 and R=64, the full-scale inputs −32768 and 32767 settle to −2^33 and 32767·2^18.
- R8: `ratio` may be any integer from 2 to R_MAX. Both ends of the range work, and with R of 2 or more, no two results are back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| ratio | input | RATIO_W | Decimation ratio, 2 to R_MAX |
| out_valid | output | 1 | Result strobe, one per R accepted samples |
| out_data | output | ACC_W | Signed full-precision result |

## Verification
The checker assumes that `ratio` stays within 2 to R_MAX whenever reset is low. Its no-back-to-back property and the counter width both depend on this. The stimulus only ever programs ratios from that range, and it changes the ratio only at a falling clock edge. Random gaps in `in_valid` test that the filter holds its state during idle cycles. Full-scale constant runs at R=64 test the top of the internal width.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Register width that holds the full gain R^N without loss.
  function automatic int cic_acc_width(input int in_w, input int stages, input int r_max);
    return in_w + stages * $clog2(r_max);
  endfunction
endpackage

// File: rtl/cic_rate_counter.sv
module cic_rate_counter #(
  parameter int RATIO_W = 7,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  logic [CNT_W-1:0] cnt;

  // The sign bit is the terminal count. No other decoding is needed.
  assign tick = step & cnt[CNT_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (step) begin
      if (cnt[CNT_W-1]) cnt <= CNT_W'(ratio) - CNT_W'(2);
      else              cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cic_integrator_chain.sv
module cic_integrator_chain #(
  parameter int ACC_W  = 34,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] sum_next
);
  logic signed [ACC_W-1:0] acc [STAGES];
  logic signed [ACC_W-1:0] nxt [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign nxt[i] = acc[i] + din;
      end else begin : g_rest
        assign nxt[i] = acc[i] + nxt[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst)     acc[i] <= '0;
        else if (en) acc[i] <= nxt[i];
      end
    end
  endgenerate

  assign sum_next = nxt[STAGES-1];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ACC_W  = 34,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] din,
  output logic                    dout_valid,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] dly  [STAGES];
  logic signed [ACC_W-1:0] diff [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign diff[i] = din - dly[i];
        always_ff @(posedge clk) begin
          if (rst)     dly[i] <= '0;
          else if (en) dly[i] <= din;
        end
      end else begin : g_rest
        assign diff[i] = diff[i-1] - dly[i];
        always_ff @(posedge clk) begin
          if (rst)     dly[i] <= '0;
          else if (en) dly[i] <= diff[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= en;
      if (en) dout <= diff[STAGES-1];
    end
  end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator
  import cic_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int STAGES  = 3,
  parameter int R_MAX   = 64,
  parameter int RATIO_W = $clog2(R_MAX + 1),
  parameter int ACC_W   = cic_acc_width(IN_W, STAGES, R_MAX)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic [RATIO_W-1:0]      ratio,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);
  localparam int CNT_W = $clog2(R_MAX - 1) + 1;

  logic                    dec_tick;
  logic signed [ACC_W-1:0] din_ext;
  logic signed [ACC_W-1:0] integ_out;

  assign din_ext = ACC_W'(in_data);

  cic_rate_counter #(.RATIO_W(RATIO_W), .CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst(rst), .step(in_valid), .ratio(ratio), .tick(dec_tick)
  );

  cic_integrator_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk(clk), .rst(rst), .en(in_valid), .din(din_ext), .sum_next(integ_out)
  );

  cic_comb_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk(clk), .rst(rst), .en(dec_tick), .din(integ_out),
    .dout_valid(out_valid), .dout(out_data)
  );
endmodule

// File: rtl/cic_decimator_checker.sv
module cic_decimator_checker #(
  parameter int RATIO_W = 7,
  parameter int ACC_W   = 34,
  parameter int R_MAX   = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [RATIO_W-1:0] ratio,
  input logic               out_valid,
  input logic [ACC_W-1:0]   out_data
);
  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ratio >= RATIO_W'(2)) && (ratio <= RATIO_W'(R_MAX))); // R8

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R8

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R5

  AST_HOLD_BETWEEN_RESULTS: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data)); // R5

  AST_RESULT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R2
endmodule

bind cic_decimator cic_decimator_checker #(
  .RATIO_W(RATIO_W), .ACC_W(ACC_W), .R_MAX(R_MAX)
) u_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ratio(ratio),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/cic_decimator_test.sv
module cic_decimator_test;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W    = 16;
  localparam int N       = 3;
  localparam int R_MAX   = 64;
  localparam int RATIO_W = 7;
  localparam int ACC_W   = 34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic [RATIO_W-1:0] ratio = 7'd4;
  logic out_valid;
  logic signed [ACC_W-1:0] out_data;

  cic_decimator #(.IN_W(IN_W), .STAGES(N), .R_MAX(R_MAX)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .ratio(ratio), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint xs [0:2047];
  longint h  [0:255];
  longint ht [0:255];
  int hlen, nx, next_dec;
  bit model_data;
  logic signed [ACC_W-1:0] last_out;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // N-fold convolution of an R-long all-ones sequence
  task automatic build_h(input int r);
    for (int k = 0; k < 256; k++) h[k] = 0;
    h[0] = 1;
    hlen = 1;
    for (int s = 0; s < N; s++) begin
      for (int k = 0; k < 256; k++) begin
        ht[k] = 0;
        for (int j = 0; j < r; j++) if (k - j >= 0) ht[k] += h[k-j];
      end
      for (int k = 0; k < 256; k++) h[k] = ht[k];
      hlen = hlen + r - 1;
    end
  endtask

  function automatic longint ref_at(input int n);
    longint acc = 0;
    for (int k = 0; k < hlen; k++) if (n - k >= 0) acc += h[k] * xs[n-k];
    return acc;
  endfunction

  task automatic do_reset(input int r);
    ratio = RATIO_W'(r);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
    check(out_data == '0, "R1 data in reset", longint'(out_data), 0);
    @(negedge clk);
    rst = 1'b0;
    nx = 0; next_dec = 0; last_out = '0;
    build_h(r);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(out_valid == 1'b0 && out_data == '0, "R1 after release", longint'(out_data), 0);
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit v, input longint x);
    bit dec = 1'b0;
    longint e = 0;
    logic signed [ACC_W-1:0] et;
    in_valid = v;
    in_data = IN_W'(x);
    if (v) begin
      xs[nx] = x;
      if (nx == next_dec) begin
        dec = 1'b1;
        if (model_data) e = ref_at(nx);
        next_dec = nx + int'(ratio);
      end
      nx++;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(out_valid == dec, v ? "R2/R6 strobe timing" : "R5 idle strobe",
          longint'(out_valid), longint'(dec));
    if (dec && model_data) begin
      et = e[ACC_W-1:0];
      check(out_data == et, "R3 boxcar response", longint'(out_data), longint'(et));
    end else if (!dec) begin
      check(out_data == last_out, "R5 output hold", longint'(out_data), longint'(last_out));
    end
    last_out = out_data;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int rs [4] = '{2, 5, 13, 64};
    longint tgt;
    void'($urandom(32'd1234));
    @(negedge clk);

    // R3: impulse response at R=5
    do_reset(5);
    model_data = 1'b1;
    step(1, 1000);
    for (int i = 0; i < 30; i++) step(1, 0);

    // R3/R5/R8: random data with random idle gaps, ratios across the range
    foreach (rs[ri]) begin
      do_reset(rs[ri]);
      model_data = 1'b1;
      for (int i = 0; i < 3 * hlen + 8 * rs[ri]; i++) begin
        if ($urandom % 4 == 0) step(0, 0);
        step(1, longint'($signed(IN_W'($urandom))));
      end
    end

    // R7: full-scale constants at R=64 reach the edge of the width
    do_reset(64);
    model_data = 1'b1;
    for (int i = 0; i < 260; i++) step(1, -32768);
    tgt = -(longint'(1) <<< 33);
    check(last_out == tgt[ACC_W-1:0], "R7 negative full scale", longint'(last_out), tgt);
    do_reset(64);
    model_data = 1'b1;
    for (int i = 0; i < 260; i++) step(1, 32767);
    tgt = longint'(32767) * 262144;
    check(last_out == tgt[ACC_W-1:0], "R7 positive full scale", longint'(last_out), tgt);

    // R4/R6: constant input, ratio changed in mid-period
    do_reset(4);
    model_data = 1'b0;
    for (int i = 0; i < 41; i++) step(1, 100);
    check(last_out == 6400, "R4 settle at R=4", longint'(last_out), 6400);
    step(1, 100);
    ratio = 7'd7;
    for (int i = 0; i < 70; i++) step(1, 100);
    check(last_out == 34300, "R4/R6 settle at R=7", longint'(last_out), 34300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule